// File: doc/BRIEF.md
# Boundary-Pausing Single-Operation DMA Engine

This block is the single-operation DMA part of an SD host controller. Software programs a start address, a block length, a block count, a buffer-boundary size and a transfer mode through a small register write port. A write to the transfer-mode register with DMA enabled starts the engine. The engine then moves whole 32-bit words between a request/acknowledge memory port and the card data stream, one block after another. Reading from the card turns stream words into memory writes. Writing to the card turns memory reads into stream words.

The memory space is cut into aligned windows. The window size is a power of two that software picks. When the next address would start a new window and words still remain, the engine stops and raises a boundary status bit. It stays stopped until software writes the address register again, even with the same value. It then carries on from the value written. When the last counted block is done, the engine raises a transfer-complete status bit. If automatic stop is enabled for a multi-block transfer, it also emits a one-cycle stop-command pulse. Both status bits are cleared by writing 1 to them.

Top module: `sdma_engine`

## Requirements
- R1: After reset the address and count readbacks are 0, both status bits are 0, `busy` is 0 and no memory request is raised.
- R2: `wr_sel` picks the target of a write: 0 address, 1 block size, 2 block count, 3 transfer mode, 4 host control, 5 status clear. A mode write with bit 0 set starts a transfer only when the engine is idle and host-control bits 4:3 are 00. Any other value of that field leaves the engine idle.
- R3: Mode bit 4 sets the direction. When it is 1, card words are written to memory at consecutive word addresses starting at the programmed address. When it is 0, memory is read from that address and the words are sent to the card stream in order. After each word the address readback grows by 4.
- R4: Block-size bits 11:0 give the block length in bytes, a multiple of 4. More than one block is moved only when both count enable (mode bit 1) and multi-block (mode bit 5) are set. Otherwise exactly one block is moved. With count enable set, the count readback drops by one after each whole block and never in the middle of a block.
- R5: Block-size bits 14:12 hold k, and the boundary window is 4096 << k bytes. When a word finishes, the next address is a multiple of the window and words still remain, the engine pauses and sets the boundary status bit (status bit 1).
- R6: While paused, the engine raises no memory request and the address readback holds the next address to be used.
- R7: A write to the address register during a pause resumes the transfer from the written value. Writing the same value also resumes it.
- R8: After the last word, transfer-complete (status bit 0) is set and `busy` falls. If that last word ends exactly on a window edge, only completion is reported and the boundary bit stays 0.
- R9: A write to the status register clears each status bit whose data bit is 1 and keeps each bit whose data bit is 0. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: When mode bit 2 and multi-block are both set, `auto_stop` pulses for one cycle as the transfer completes. It does not pulse for a single-block transfer.
- R11: While a transfer is running and not paused, writes to the address, block size, block count and mode registers are ignored.
- R12: A memory request keeps `mem_req` high and holds its address stable until `mem_ack` is seen.
- R13: If count enable and multi-block are set and the block count is 0, the transfer completes without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector (see R2) |
| wr_data | input | 32 | Register write data |
| sys_addr_rd | output | 32 | Current or next address |
| blk_cnt_rd | output | 16 | Remaining block count |
| st_xfer_done | output | 1 | Transfer-complete status |
| st_dma_bound | output | 1 | Boundary-pause status |
| busy | output | 1 | Transfer active or paused |
| auto_stop | output | 1 | One-cycle stop-command request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| cin_valid | input | 1 | Card-to-host word valid |
| cin_data | input | 32 | Card-to-host word |
| cin_ready | output | 1 | Engine takes a card word |
| cout_valid | output | 1 | Host-to-card word valid |
| cout_data | output | 32 | Host-to-card word |
| cout_ready | input | 1 | Card side takes the word |

## Verification
The last word of a transfer can land on a window edge. In that cycle, the completion decision and the boundary-pause decision both apply. The bench provokes this with a single 32-byte block that ends at address 0x2000 with a 4 KiB window. It judges the result by seeing transfer-complete set, the boundary bit clear and `busy` low, while an assertion forbids both events firing together. A second overlap is a status clear that meets a status set. Here an assertion requires the set to win.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR  = 3'd0,
    SEL_BSIZE = 3'd1,
    SEL_BCNT  = 3'd2,
    SEL_MODE  = 3'd3,
    SEL_HCTL  = 3'd4,
    SEL_STAT  = 3'd5
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_CARD_IN,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_CARD_OUT,
    ST_PAUSE
  } eng_state_e;

  typedef struct packed {
    logic multi;
    logic dir_rd;
    logic auto_stop;
    logic cnt_en;
    logic dma_en;
  } xfer_mode_t;

  localparam int MODE_DMA_EN    = 0;
  localparam int MODE_CNT_EN    = 1;
  localparam int MODE_AUTO_STOP = 2;
  localparam int MODE_DIR_RD    = 4;
  localparam int MODE_MULTI     = 5;
  localparam int BSZ_BOUND_LSB  = 12;
  localparam int HCTL_SEL_LSB   = 3;
  localparam int STAT_DONE      = 0;
  localparam int STAT_BOUND     = 1;

  // Size in bytes of one boundary window.
  function automatic logic [63:0] window_span(input int base_log2, input logic [2:0] sel);
    return 64'd1 << (base_log2 + int'(sel));
  endfunction

  // True when an address is the first byte of a window.
  function automatic logic on_window_edge(input logic [63:0] addr, input int base_log2,
                                          input logic [2:0] sel);
    return (addr & (window_span(base_log2, sel) - 64'd1)) == 64'd0;
  endfunction

  // Words per block; a length shorter than one word still moves one word.
  function automatic logic [15:0] block_words(input logic [15:0] len_bytes, input int wb_log2);
    logic [15:0] w;
    w = len_bytes >> wb_log2;
    return (w == 16'd0) ? 16'd1 : w;
  endfunction

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 32,
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 12,
  parameter int WB_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              busy,
  input  logic              paused,
  input  logic              evt_step,
  input  logic              evt_blk_dec,
  input  logic              evt_done,
  input  logic              evt_pause,
  output logic [ADDR_W-1:0] sys_addr,
  output logic [LEN_W-1:0]  blk_len,
  output logic [2:0]        bound_sel,
  output logic [CNT_W-1:0]  blk_cnt,
  output xfer_mode_t        mode,
  output logic [1:0]        dma_sel,
  output logic              st_done,
  output logic              st_bound,
  output logic              start,
  output logic              resume
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(1 << WB_LOG2);

  logic wr_addr, wr_bsize, wr_bcnt, wr_mode, wr_hctl, wr_stat;
  logic clr_done, clr_bound;

  always_comb begin
    wr_addr   = wr_en && (reg_sel_e'(wr_sel) == SEL_ADDR) && (!busy || paused);
    wr_bsize  = wr_en && (reg_sel_e'(wr_sel) == SEL_BSIZE) && !busy;
    wr_bcnt   = wr_en && (reg_sel_e'(wr_sel) == SEL_BCNT) && !busy;
    wr_mode   = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE) && !busy;
    wr_hctl   = wr_en && (reg_sel_e'(wr_sel) == SEL_HCTL);
    wr_stat   = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT);
    clr_done  = wr_stat && wr_data[STAT_DONE];
    clr_bound = wr_stat && wr_data[STAT_BOUND];
    start     = wr_mode && wr_data[MODE_DMA_EN] && (dma_sel == 2'b00);
    resume    = wr_addr && paused;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_addr <= '0;
    end else if (wr_addr) begin
      sys_addr <= wr_data[ADDR_W-1:0];
    end else if (evt_step) begin
      sys_addr <= sys_addr + WORD_BYTES;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_len   <= '0;
      bound_sel <= '0;
    end else if (wr_bsize) begin
      blk_len   <= wr_data[LEN_W-1:0];
      bound_sel <= wr_data[BSZ_BOUND_LSB +: 3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= '0;
    end else if (wr_bcnt) begin
      blk_cnt <= wr_data[CNT_W-1:0];
    end else if (evt_blk_dec) begin
      blk_cnt <= blk_cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (wr_mode) begin
      mode.dma_en    <= wr_data[MODE_DMA_EN];
      mode.cnt_en    <= wr_data[MODE_CNT_EN];
      mode.auto_stop <= wr_data[MODE_AUTO_STOP];
      mode.dir_rd    <= wr_data[MODE_DIR_RD];
      mode.multi     <= wr_data[MODE_MULTI];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_sel <= 2'b00;
    end else if (wr_hctl) begin
      dma_sel <= wr_data[HCTL_SEL_LSB +: 2];
    end
  end

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done  <= 1'b0;
      st_bound <= 1'b0;
    end else begin
      st_done  <= evt_done  || (st_done  && !clr_done);
      st_bound <= evt_pause || (st_bound && !clr_bound);
    end
  end

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int LEN_W     = 12,
  parameter int BASE_LOG2 = 12,
  parameter int WB_LOG2   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [2:0]        bound_sel,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  xfer_mode_t        mode,
  input  logic              mem_ack,
  input  logic              cin_valid,
  input  logic              cout_ready,
  output logic              busy,
  output logic              paused,
  output logic              mem_req,
  output logic              mem_we,
  output logic              cin_ready,
  output logic              cout_valid,
  output logic              ld_card,
  output logic              ld_mem,
  output logic              evt_step,
  output logic              evt_blk_dec,
  output logic              evt_done,
  output logic              evt_pause,
  output logic              auto_stop
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(1 << WB_LOG2);

  eng_state_e          state_q, state_d;
  logic [LEN_W-1:0]    word_idx_q;
  logic [15:0]         words;
  logic                last_word, last_block, multi_cnt, empty_xfer;
  logic [ADDR_W-1:0]   next_addr;
  logic                edge_hit;
  eng_state_e          first_st;
  logic                auto_stop_q;

  always_comb begin
    words      = block_words(16'(blk_len), WB_LOG2);
    last_word  = (16'(word_idx_q) == (words - 16'd1));
    multi_cnt  = mode.cnt_en && mode.multi;
    last_block = !multi_cnt || (blk_cnt == CNT_W'(1));
    empty_xfer = multi_cnt && (blk_cnt == '0);
    next_addr  = sys_addr + WORD_BYTES;
    edge_hit   = on_window_edge(64'(next_addr), BASE_LOG2, bound_sel);
    first_st   = mode.dir_rd ? ST_CARD_IN : ST_MEM_RD;
  end

  always_comb begin
    busy       = (state_q != ST_IDLE);
    paused     = (state_q == ST_PAUSE);
    mem_req    = (state_q == ST_MEM_WR) || (state_q == ST_MEM_RD);
    mem_we     = (state_q == ST_MEM_WR);
    cin_ready  = (state_q == ST_CARD_IN);
    cout_valid = (state_q == ST_CARD_OUT);
    ld_card    = cin_ready && cin_valid;
    ld_mem     = (state_q == ST_MEM_RD) && mem_ack;
    evt_step   = ((state_q == ST_MEM_WR) && mem_ack) ||
                 ((state_q == ST_CARD_OUT) && cout_ready);
    evt_blk_dec = evt_step && last_word && mode.cnt_en;
    evt_done   = (evt_step && last_word && last_block) ||
                 ((state_q == ST_LAUNCH) && empty_xfer);
    evt_pause  = evt_step && !(last_word && last_block) && edge_hit;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start) state_d = ST_LAUNCH;
      ST_LAUNCH:   state_d = empty_xfer ? ST_IDLE : first_st;
      ST_CARD_IN:  if (cin_valid) state_d = ST_MEM_WR;
      ST_MEM_RD:   if (mem_ack) state_d = ST_CARD_OUT;
      ST_MEM_WR,
      ST_CARD_OUT: begin
        if (evt_done)       state_d = ST_IDLE;
        else if (evt_pause) state_d = ST_PAUSE;
        else if (evt_step)  state_d = first_st;
      end
      ST_PAUSE:    if (resume) state_d = first_st;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      word_idx_q  <= '0;
      auto_stop_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      auto_stop_q <= evt_done && mode.auto_stop && mode.multi;
      if (state_q == ST_LAUNCH) begin
        word_idx_q <= '0;
      end else if (evt_step) begin
        word_idx_q <= last_word ? '0 : word_idx_q + LEN_W'(1);
      end
    end
  end

  assign auto_stop = auto_stop_q;

endmodule

// File: rtl/sdma_word_buf.sv
module sdma_word_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_card,
  input  logic              ld_mem,
  input  logic [DATA_W-1:0] card_word,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] held_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_word <= '0;
    end else if (ld_card) begin
      held_word <= card_word;
    end else if (ld_mem) begin
      held_word <= mem_word;
    end
  end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int LEN_W     = 12,
  parameter int BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic [ADDR_W-1:0] sys_addr_rd,
  output logic [CNT_W-1:0]  blk_cnt_rd,
  output logic              st_xfer_done,
  output logic              st_dma_bound,
  output logic              busy,
  output logic              auto_stop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              cin_valid,
  input  logic [DATA_W-1:0] cin_data,
  output logic              cin_ready,
  output logic              cout_valid,
  output logic [DATA_W-1:0] cout_data,
  input  logic              cout_ready
);

  localparam int WB_LOG2 = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] sys_addr;
  logic [LEN_W-1:0]  blk_len;
  logic [2:0]        bound_sel;
  logic [CNT_W-1:0]  blk_cnt;
  xfer_mode_t        mode;
  logic [1:0]        dma_sel_q;
  logic              start, resume, paused;
  logic              evt_step, evt_blk_dec, evt_done, evt_pause;
  logic              ld_card, ld_mem;
  logic [DATA_W-1:0] held_word;

  sdma_regs #(
    .ADDR_W(ADDR_W), .REG_W(32), .CNT_W(CNT_W), .LEN_W(LEN_W), .WB_LOG2(WB_LOG2)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .paused(paused), .evt_step(evt_step), .evt_blk_dec(evt_blk_dec),
    .evt_done(evt_done), .evt_pause(evt_pause), .sys_addr(sys_addr), .blk_len(blk_len),
    .bound_sel(bound_sel), .blk_cnt(blk_cnt), .mode(mode), .dma_sel(dma_sel_q),
    .st_done(st_xfer_done), .st_bound(st_dma_bound), .start(start), .resume(resume)
  );

  sdma_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .BASE_LOG2(BASE_LOG2), .WB_LOG2(WB_LOG2)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .sys_addr(sys_addr),
    .blk_len(blk_len), .bound_sel(bound_sel), .blk_cnt(blk_cnt), .mode(mode),
    .mem_ack(mem_ack), .cin_valid(cin_valid), .cout_ready(cout_ready), .busy(busy),
    .paused(paused), .mem_req(mem_req), .mem_we(mem_we), .cin_ready(cin_ready),
    .cout_valid(cout_valid), .ld_card(ld_card), .ld_mem(ld_mem), .evt_step(evt_step),
    .evt_blk_dec(evt_blk_dec), .evt_done(evt_done), .evt_pause(evt_pause),
    .auto_stop(auto_stop)
  );

  sdma_word_buf #(.DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .ld_card(ld_card), .ld_mem(ld_mem),
    .card_word(cin_data), .mem_word(mem_rdata), .held_word(held_word)
  );

  assign sys_addr_rd = sys_addr;
  assign blk_cnt_rd  = blk_cnt;
  assign mem_addr    = sys_addr;
  assign mem_wdata   = held_word;
  assign cout_data   = held_word;

endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              paused,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] sys_addr_rd,
  input logic              st_xfer_done,
  input logic              st_dma_bound,
  input logic [1:0]        dma_sel_q,
  input logic              evt_step,
  input logic              evt_done,
  input logic              evt_pause
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  AST_PAUSE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !mem_req); // R6

  AST_PAUSE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && $past(paused)) |-> $stable(sys_addr_rd)); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R12

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_step |=> (sys_addr_rd == $past(sys_addr_rd) + STEP)); // R3

  AST_PAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pause |=> (st_dma_bound && paused)); // R5

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> (st_xfer_done && !busy)); // R8

  AST_DONE_EXCLUDES_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !evt_pause); // R8

  AST_START_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dma_sel_q == 2'b00)); // R2

endmodule

bind sdma_engine sdma_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .paused(paused), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .sys_addr_rd(sys_addr_rd),
  .st_xfer_done(st_xfer_done), .st_dma_bound(st_dma_bound), .dma_sel_q(dma_sel_q),
  .evt_step(evt_step), .evt_done(evt_done), .evt_pause(evt_pause)
);

// File: tb/sdma_engine_tb.sv
module sdma_engine_tb_top;

  localparam logic [2:0] R_ADDR = 3'd0, R_BSIZE = 3'd1, R_BCNT = 3'd2,
                         R_MODE = 3'd3, R_HCTL = 3'd4, R_STAT = 3'd5;
  localparam logic [31:0] PAT = 32'hC0DE_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sys_addr_rd, mem_addr, mem_wdata, cout_data;
  logic [15:0] blk_cnt_rd;
  logic        st_xfer_done, st_dma_bound, busy, auto_stop;
  logic        mem_req, mem_we, cin_ready, cout_valid;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        src_en = 1'b1;
  logic [31:0] src_idx = '0;
  logic        cin_valid;
  logic [31:0] cin_data;

  int nchecks = 0, nerrs = 0;
  logic [31:0] mem_m [0:2047];
  logic [31:0] sink_m [0:63];
  int sink_n = 0, ack_delay = 0, wait_n = 0, hold_err = 0;
  int req_cnt = 0, astop_cnt = 0;
  logic [31:0] held_a = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign cin_valid = src_en;
  assign cin_data  = PAT + src_idx;

  sdma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sys_addr_rd(sys_addr_rd), .blk_cnt_rd(blk_cnt_rd), .st_xfer_done(st_xfer_done),
    .st_dma_bound(st_dma_bound), .busy(busy), .auto_stop(auto_stop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .cin_valid(cin_valid),
    .cin_data(cin_data), .cin_ready(cin_ready), .cout_valid(cout_valid),
    .cout_data(cout_data), .cout_ready(1'b1)
  );

  // Memory model: acknowledges after ack_delay wait cycles, checks the address is held.
  always @(posedge clk) begin
    if (mem_req) req_cnt <= req_cnt + 1;
    if (auto_stop) astop_cnt <= astop_cnt + 1;
    if (mem_req && !mem_ack) begin
      if (wait_n == 0) held_a <= mem_addr;
      else if (mem_addr != held_a) hold_err <= hold_err + 1;
      if (wait_n < ack_delay) begin
        wait_n <= wait_n + 1;
      end else begin
        wait_n  <= 0;
        mem_ack <= 1'b1;
        if (mem_we) mem_m[mem_addr[12:2]] <= mem_wdata;
        else        mem_rdata <= mem_m[mem_addr[12:2]];
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (cin_valid && cin_ready) src_idx <= src_idx + 1;
    if (cout_valid) begin
      if (sink_n < 64) sink_m[sink_n] <= cout_data;
      sink_n <= sink_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_for(input bit want_bound, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (want_bound ? st_dma_bound : st_xfer_done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  function automatic int mem_mismatch(input logic [31:0] a0, input int n, input logic [31:0] base);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (mem_m[a0[12:2] + 11'(i)] !== base + 32'(i)) bad++;
    return bad;
  endfunction

  task automatic t_reset;
    chk("R1", "addr", sys_addr_rd, 32'h0);
    chk("R1", "count", 32'(blk_cnt_rd), 32'h0);
    chk("R1", "status", {30'h0, st_dma_bound, st_xfer_done}, 32'h0);
    chk("R1", "busy/req", {30'h0, busy, mem_req}, 32'h0);
  endtask

  task automatic t_readback;
    reg_write(R_ADDR, 32'h1234_5678);
    reg_write(R_BCNT, 32'h0000_00AB);
    chk("R2", "addr readback", sys_addr_rd, 32'h1234_5678);
    chk("R2", "count readback", 32'(blk_cnt_rd), 32'h0000_00AB);
  endtask

  task automatic t_bad_sel;
    int r0;
    reg_write(R_HCTL, 32'h10);
    reg_write(R_BSIZE, 32'd16);
    reg_write(R_BCNT, 32'd1);
    reg_write(R_ADDR, 32'h900);
    r0 = req_cnt;
    reg_write(R_MODE, 32'h13);
    repeat (10) @(negedge clk);
    chk("R2", "no start with select 10", {31'h0, busy}, 32'h0);
    chk("R2", "no requests", 32'(req_cnt - r0), 32'h0);
    reg_write(R_HCTL, 32'h0);
  endtask

  task automatic t_read_pause;
    bit seen;
    int r0;
    logic [31:0] base;
    base = PAT + src_idx;
    reg_write(R_BSIZE, (32'd0 << 12) | 32'd32);
    reg_write(R_BCNT, 32'd2);
    reg_write(R_ADDR, 32'hFF0);
    reg_write(R_MODE, 32'h33);
    wait_for(1'b1, seen);
    chk("R5", "pause at 4 KiB edge", {31'h0, seen}, 32'h1);
    chk("R6", "address while paused", sys_addr_rd, 32'h1000);
    chk("R4", "count mid-block", 32'(blk_cnt_rd), 32'd2);
    chk("R5", "busy/done while paused", {30'h0, busy, st_xfer_done}, 32'h2);
    r0 = req_cnt;
    repeat (20) @(negedge clk);
    chk("R6", "no requests while paused", 32'(req_cnt - r0), 32'h0);
    reg_write(R_STAT, 32'h0);
    chk("R9", "zero write keeps bit", {31'h0, st_dma_bound}, 32'h1);
    reg_write(R_STAT, 32'h2);
    chk("R9", "one clears bit", {31'h0, st_dma_bound}, 32'h0);
    reg_write(R_ADDR, 32'h1000);
    wait_for(1'b0, seen);
    chk("R7", "resume then complete", {31'h0, seen}, 32'h1);
    chk("R3", "card words in memory", 32'(mem_mismatch(32'hFF0, 16, base)), 32'h0);
    chk("R4", "count after two blocks", 32'(blk_cnt_rd), 32'h0);
    chk("R3", "final address", sys_addr_rd, 32'h1030);
    reg_write(R_STAT, 32'h3);
  endtask

  task automatic t_wide_window;
    bit seen;
    logic [31:0] base;
    base = PAT + src_idx;
    reg_write(R_BSIZE, (32'd1 << 12) | 32'd32);
    reg_write(R_ADDR, 32'hFF0);
    reg_write(R_MODE, 32'h11);
    wait_for(1'b0, seen);
    chk("R5", "8 KiB window completes", {31'h0, seen}, 32'h1);
    chk("R5", "no pause at 0x1000", {31'h0, st_dma_bound}, 32'h0);
    chk("R3", "address", sys_addr_rd, 32'h1010);
    chk("R3", "data", 32'(mem_mismatch(32'hFF0, 8, base)), 32'h0);
    reg_write(R_STAT, 32'h3);
  endtask

  task automatic t_end_on_edge;
    bit seen;
    int a0;
    a0 = astop_cnt;
    reg_write(R_BSIZE, 32'd32);
    reg_write(R_ADDR, 32'h1FE0);
    reg_write(R_MODE, 32'h15);
    wait_for(1'b0, seen);
    repeat (2) @(negedge clk);
    chk("R8", "complete on edge", {31'h0, seen}, 32'h1);
    chk("R8", "no boundary flag", {31'h0, st_dma_bound}, 32'h0);
    chk("R8", "idle", {31'h0, busy}, 32'h0);
    chk("R8", "address", sys_addr_rd, 32'h2000);
    chk("R10", "no stop pulse single block", 32'(astop_cnt - a0), 32'h0);
    reg_write(R_STAT, 32'h3);
  endtask

  task automatic t_single_block;
    bit seen;
    reg_write(R_BSIZE, 32'd16);
    reg_write(R_BCNT, 32'd3);
    reg_write(R_ADDR, 32'h300);
    reg_write(R_MODE, 32'h31);
    wait_for(1'b0, seen);
    chk("R4", "one block without count enable", sys_addr_rd, 32'h310);
    chk("R4", "count untouched", 32'(blk_cnt_rd), 32'd3);
    reg_write(R_STAT, 32'h3);
  endtask

  task automatic t_write_dir;
    bit seen;
    int a0, bad;
    for (int i = 0; i < 12; i++) mem_m[11'h100 + 11'(i)] = 32'h5A00_0000 + 32'(i);
    sink_n = 0;
    ack_delay = 3;
    a0 = astop_cnt;
    reg_write(R_BSIZE, 32'd16);
    reg_write(R_BCNT, 32'd3);
    reg_write(R_ADDR, 32'h400);
    reg_write(R_MODE, 32'h27);
    wait_for(1'b0, seen);
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 12; i++) if (sink_m[i] !== 32'h5A00_0000 + 32'(i)) bad++;
    chk("R3", "words sent to card", 32'(sink_n), 32'd12);
    chk("R3", "card word order", 32'(bad), 32'h0);
    chk("R4", "count after three blocks", 32'(blk_cnt_rd), 32'h0);
    chk("R10", "stop pulse count", 32'(astop_cnt - a0), 32'h1);
    chk("R12", "address held until ack", 32'(hold_err), 32'h0);
    ack_delay = 0;
    reg_write(R_STAT, 32'h3);
  endtask

  task automatic t_busy_ignore;
    bit seen;
    src_en = 1'b0;
    reg_write(R_BSIZE, 32'd16);
    reg_write(R_BCNT, 32'd1);
    reg_write(R_ADDR, 32'h600);
    reg_write(R_MODE, 32'h13);
    reg_write(R_ADDR, 32'h700);
    reg_write(R_BCNT, 32'd9);
    reg_write(R_BSIZE, 32'd64);
    chk("R11", "address write ignored", sys_addr_rd, 32'h600);
    chk("R11", "count write ignored", 32'(blk_cnt_rd), 32'd1);
    chk("R11", "still running", {31'h0, busy}, 32'h1);
    src_en = 1'b1;
    wait_for(1'b0, seen);
    chk("R11", "size write ignored", sys_addr_rd, 32'h610);
    reg_write(R_STAT, 32'h3);
  endtask

  task automatic t_zero_count;
    bit seen;
    int r0;
    r0 = req_cnt;
    reg_write(R_BCNT, 32'd0);
    reg_write(R_ADDR, 32'h800);
    reg_write(R_MODE, 32'h33);
    wait_for(1'b0, seen);
    chk("R13", "empty transfer completes", {31'h0, seen}, 32'h1);
    chk("R13", "no requests", 32'(req_cnt - r0), 32'h0);
    chk("R13", "address unchanged", sys_addr_rd, 32'h800);
    reg_write(R_STAT, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_bad_sel();
    t_read_pause();
    t_wide_window();
    t_end_on_edge();
    t_single_block();
    t_write_dir();
    t_busy_ignore();
    t_zero_count();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchecks++;
      nerrs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

endmodule